// File: doc/BRIEF.md
# Register ALU Execute Subset

This block decodes and executes a small family of integer register-format instructions for a core with thirty-two 32-bit general registers. The family covers subtraction in both operand orders, a flag-only AND test, exclusive-OR with a register or with a 16-bit immediate, and in-place sign or zero extension of a register's low byte or low halfword. The instruction's first halfword carries two 5-bit register fields and a 6-bit opcode. A second halfword supplies the immediate for the one 32-bit form.

The surrounding core sends the instruction halfwords with a valid strobe. From the first halfword the block drives the two register-file read indices, and the register file returns both operands in the same cycle. One clock edge later the block presents the write-back index, write data and write enable. It also presents the new condition flags, a flag-update strobe and an illegal-instruction indication. Fetch, the register file, the pipeline and memory are outside the block.

Top module: `rx_alu_subset`

## Requirements
- R1: The first halfword is decoded with the destination field in bits 15:11, the opcode in bits 10:5 and the source field in bits 4:0. Any opcode outside the set listed below, and any extension opcode whose bits 15:11 are not 00000, raises `illegal_o`. An illegal instruction writes no register, does not strobe `flags_we_o`, and returns the incoming flags on `flags_o` unchanged.
- R2: Opcode 001101 (subtract) writes GR[dst] − GR[src] into GR[dst]. CY is set on unsigned borrow and OV on signed overflow of that difference.
- R3: Opcode 001100 (reverse subtract) writes GR[src] − GR[dst] into GR[dst]. CY and OV follow the same rules as R2 for this difference.
- R4: Opcode 001011 (test) computes GR[dst] AND GR[src] and writes no register. It strobes the flags, setting S and Z from the AND result, clearing OV and leaving CY unchanged.
- R5: Opcode 001001 (exclusive-OR) writes GR[dst] XOR GR[src] into GR[dst]. It clears OV, leaves CY unchanged, and sets S and Z from the result.
- R6: Opcode 110101 (exclusive-OR immediate) writes GR[src] XOR the zero-extended second halfword into GR[dst]. It clears OV, leaves CY unchanged, and sets S and Z from the result.
- R7: With bits 15:11 equal to 00000, four extension opcodes rewrite GR[src] in place: 000100 zero-extends bits 7:0, 000101 sign-extends bits 7:0, 000110 zero-extends bits 15:0 and 000111 sign-extends bits 15:0. These opcodes do not strobe the flags, and `flags_o` equals the incoming flags.
- R8: On `flags_i`/`flags_o` the bit order is bit 0 Z, bit 1 S, bit 2 OV, bit 3 CY. For every flag-updating operation, S equals result bit 31 and Z is set exactly when the 32-bit result is zero.
- R9: Register 0 reads as zero whatever data the register file returns for it. A result destined for register 0 is discarded (`wb_en_o` low), but the flags are still updated.
- R10: Each instruction accepted with `valid_i` high produces its outputs with `valid_o` high after exactly one rising clock edge. Whenever `valid_o` is low, `wb_en_o`, `flags_we_o` and `illegal_o` are low.
- R11: While `rst_ni` is low, every output register holds zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction present this cycle |
| insn_lo_i | input | 16 | First instruction halfword |
| insn_hi_i | input | 16 | Second halfword (immediate) |
| src_rdata_i | input | 32 | Register-file data for the source field |
| dst_rdata_i | input | 32 | Register-file data for the destination field |
| flags_i | input | 4 | Current flags {CY,OV,S,Z} |
| src_idx_o | output | 5 | Read index for the source operand |
| dst_idx_o | output | 5 | Read index for the destination operand |
| valid_o | output | 1 | Result stage holds an instruction |
| wb_en_o | output | 1 | Register write enable |
| wb_idx_o | output | 5 | Register write index |
| wb_data_o | output | 32 | Register write data |
| flags_we_o | output | 1 | Flags updated by this instruction |
| flags_o | output | 4 | Resulting flags {CY,OV,S,Z} |
| illegal_o | output | 1 | Instruction not recognised |

## Verification
The in-line assertions check the control invariants on every cycle. They confirm that an illegal instruction never writes, that register 0 is never a write target, and that the latency is exactly one edge. They also confirm that an idle result stage is quiet, that S and Z agree with the written data, and that flags pass through unchanged whenever they are not updated. The arithmetic itself can only be shown by the bench's scenarios: borrow and signed-overflow corners of both subtract orders, zero extension of an immediate with its top bit set, sign versus zero extension of negative bytes and halfwords, and garbage read data behind register 0.

// File: rtl/rx_alu_pkg.sv
package rx_alu_pkg;
  localparam int unsigned XLEN   = 32;
  localparam int unsigned REG_AW = 5;
  localparam int unsigned HW     = 16;
  localparam int unsigned OPC_W  = 6;
  localparam int unsigned NFLG   = 4;

  localparam int unsigned FLG_Z  = 0;
  localparam int unsigned FLG_S  = 1;
  localparam int unsigned FLG_OV = 2;
  localparam int unsigned FLG_CY = 3;

  localparam logic [OPC_W-1:0] OPC_SUB  = 6'b001101;
  localparam logic [OPC_W-1:0] OPC_SUBR = 6'b001100;
  localparam logic [OPC_W-1:0] OPC_TST  = 6'b001011;
  localparam logic [OPC_W-1:0] OPC_XOR  = 6'b001001;
  localparam logic [OPC_W-1:0] OPC_XORI = 6'b110101;
  localparam logic [OPC_W-1:0] OPC_ZXB  = 6'b000100;
  localparam logic [OPC_W-1:0] OPC_SXB  = 6'b000101;
  localparam logic [OPC_W-1:0] OPC_ZXH  = 6'b000110;
  localparam logic [OPC_W-1:0] OPC_SXH  = 6'b000111;

  typedef enum logic [3:0] {
    OP_ILL, OP_SUB, OP_SUBR, OP_TST, OP_XOR, OP_XORI,
    OP_ZXB, OP_SXB, OP_ZXH, OP_SXH
  } alu_op_e;
endpackage

// File: rtl/rx_alu_decode.sv
module rx_alu_decode
  import rx_alu_pkg::*;
#(
  parameter int unsigned RAW = REG_AW,
  parameter int unsigned OW  = OPC_W,
  parameter int unsigned HWW = HW
) (
  input  logic [HWW-1:0] insn_i,
  output alu_op_e        op_o,
  output logic [RAW-1:0] src_idx_o,
  output logic [RAW-1:0] dst_idx_o,
  output logic [RAW-1:0] wb_idx_o,
  output logic           writes_o,
  output logic           flag_upd_o
);
  localparam int unsigned OPC_LSB = RAW;
  localparam int unsigned DST_LSB = RAW + OW;

  logic [OW-1:0]  opc;
  logic [RAW-1:0] f_dst, f_src;
  logic           dst_zero;

  assign f_src    = insn_i[RAW-1:0];
  assign opc      = insn_i[OPC_LSB +: OW];
  assign f_dst    = insn_i[DST_LSB +: RAW];
  assign dst_zero = (f_dst == '0);

  always_comb begin
    op_o = OP_ILL;
    unique case (opc)
      OPC_SUB:  op_o = OP_SUB;
      OPC_SUBR: op_o = OP_SUBR;
      OPC_TST:  op_o = OP_TST;
      OPC_XOR:  op_o = OP_XOR;
      OPC_XORI: op_o = OP_XORI;
      OPC_ZXB:  op_o = dst_zero ? OP_ZXB : OP_ILL;
      OPC_SXB:  op_o = dst_zero ? OP_SXB : OP_ILL;
      OPC_ZXH:  op_o = dst_zero ? OP_ZXH : OP_ILL;
      OPC_SXH:  op_o = dst_zero ? OP_SXH : OP_ILL;
      default:  op_o = OP_ILL;
    endcase
  end

  logic is_ext;
  assign is_ext     = (op_o inside {OP_ZXB, OP_SXB, OP_ZXH, OP_SXH});
  assign flag_upd_o = (op_o inside {OP_SUB, OP_SUBR, OP_TST, OP_XOR, OP_XORI});
  assign writes_o   = (op_o != OP_ILL) && (op_o != OP_TST);
  assign src_idx_o  = f_src;
  assign dst_idx_o  = f_dst;
  // extension ops write back in place on the source register
  assign wb_idx_o   = is_ext ? f_src : f_dst;
endmodule

// File: rtl/rx_alu_exec.sv
module rx_alu_exec
  import rx_alu_pkg::*;
#(
  parameter int unsigned W   = XLEN,
  parameter int unsigned IMW = HW
) (
  input  alu_op_e        op_i,
  input  logic [W-1:0]   src_i,
  input  logic [W-1:0]   dst_i,
  input  logic [IMW-1:0] imm_i,
  output logic [W-1:0]   res_o,
  output logic           cy_o,
  output logic           ov_o
);
  localparam int unsigned NEXT = 2;

  // ext_z[k]/ext_s[k]: zero/sign extension of the low 8<<k bits
  logic [W-1:0] ext_z [NEXT];
  logic [W-1:0] ext_s [NEXT];

  for (genvar k = 0; k < NEXT; k++) begin : g_ext
    localparam int unsigned EW = 8 << k;
    assign ext_z[k] = {{(W-EW){1'b0}},         src_i[EW-1:0]};
    assign ext_s[k] = {{(W-EW){src_i[EW-1]}},  src_i[EW-1:0]};
  end

  logic         rev;
  logic [W-1:0] min_a, sub_b;
  logic [W:0]   diff;

  assign rev   = (op_i == OP_SUBR);
  assign min_a = rev ? src_i : dst_i;
  assign sub_b = rev ? dst_i : src_i;
  assign diff  = {1'b0, min_a} - {1'b0, sub_b};

  always_comb begin
    res_o = '0;
    cy_o  = 1'b0;
    ov_o  = 1'b0;
    unique case (op_i)
      OP_SUB, OP_SUBR: begin
        res_o = diff[W-1:0];
        cy_o  = diff[W];
        ov_o  = (min_a[W-1] ^ sub_b[W-1]) & (diff[W-1] ^ min_a[W-1]);
      end
      OP_TST:  res_o = dst_i & src_i;
      OP_XOR:  res_o = dst_i ^ src_i;
      OP_XORI: res_o = src_i ^ {{(W-IMW){1'b0}}, imm_i};
      OP_ZXB:  res_o = ext_z[0];
      OP_SXB:  res_o = ext_s[0];
      OP_ZXH:  res_o = ext_z[1];
      OP_SXH:  res_o = ext_s[1];
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/rx_alu_flags.sv
module rx_alu_flags
  import rx_alu_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  alu_op_e         op_i,
  input  logic [W-1:0]    res_i,
  input  logic            cy_i,
  input  logic            ov_i,
  input  logic [NFLG-1:0] flags_i,
  output logic [NFLG-1:0] flags_o
);
  always_comb begin
    flags_o = flags_i;
    unique case (op_i)
      OP_SUB, OP_SUBR: begin
        flags_o[FLG_CY] = cy_i;
        flags_o[FLG_OV] = ov_i;
        flags_o[FLG_S]  = res_i[W-1];
        flags_o[FLG_Z]  = (res_i == '0);
      end
      OP_TST, OP_XOR, OP_XORI: begin
        flags_o[FLG_OV] = 1'b0;
        flags_o[FLG_S]  = res_i[W-1];
        flags_o[FLG_Z]  = (res_i == '0);
      end
      default: flags_o = flags_i;
    endcase
  end
endmodule

// File: rtl/rx_alu_subset.sv
module rx_alu_subset
  import rx_alu_pkg::*;
#(
  parameter int unsigned W   = XLEN,
  parameter int unsigned RAW = REG_AW,
  parameter int unsigned HWW = HW,
  parameter int unsigned NF  = NFLG
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           valid_i,
  input  logic [HWW-1:0] insn_lo_i,
  input  logic [HWW-1:0] insn_hi_i,
  input  logic [W-1:0]   src_rdata_i,
  input  logic [W-1:0]   dst_rdata_i,
  input  logic [NF-1:0]  flags_i,
  output logic [RAW-1:0] src_idx_o,
  output logic [RAW-1:0] dst_idx_o,
  output logic           valid_o,
  output logic           wb_en_o,
  output logic [RAW-1:0] wb_idx_o,
  output logic [W-1:0]   wb_data_o,
  output logic           flags_we_o,
  output logic [NF-1:0]  flags_o,
  output logic           illegal_o
);
  alu_op_e        op;
  logic [RAW-1:0] wb_idx_d;
  logic           writes, flag_upd;
  logic [W-1:0]   src_op, dst_op, res;
  logic           cy, ov;
  logic [NF-1:0]  flags_d;

  rx_alu_decode #(.RAW(RAW), .OW(OPC_W), .HWW(HWW)) i_decode (
    .insn_i     (insn_lo_i),
    .op_o       (op),
    .src_idx_o  (src_idx_o),
    .dst_idx_o  (dst_idx_o),
    .wb_idx_o   (wb_idx_d),
    .writes_o   (writes),
    .flag_upd_o (flag_upd)
  );

  // register 0 is hard-wired to zero regardless of read data
  assign src_op = (src_idx_o == '0) ? '0 : src_rdata_i;
  assign dst_op = (dst_idx_o == '0) ? '0 : dst_rdata_i;

  rx_alu_exec #(.W(W), .IMW(HWW)) i_exec (
    .op_i  (op),
    .src_i (src_op),
    .dst_i (dst_op),
    .imm_i (insn_hi_i),
    .res_o (res),
    .cy_o  (cy),
    .ov_o  (ov)
  );

  rx_alu_flags #(.W(W)) i_flags (
    .op_i    (op),
    .res_i   (res),
    .cy_i    (cy),
    .ov_i    (ov),
    .flags_i (flags_i),
    .flags_o (flags_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      wb_en_o    <= 1'b0;
      wb_idx_o   <= '0;
      wb_data_o  <= '0;
      flags_we_o <= 1'b0;
      flags_o    <= '0;
      illegal_o  <= 1'b0;
    end else begin
      valid_o    <= valid_i;
      wb_en_o    <= valid_i && writes && (wb_idx_d != '0);
      wb_idx_o   <= wb_idx_d;
      wb_data_o  <= res;
      flags_we_o <= valid_i && flag_upd;
      flags_o    <= flags_d;
      illegal_o  <= valid_i && (op == OP_ILL);
    end
  end

  AST_ILLEGAL_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!wb_en_o && !flags_we_o)); // R1
  AST_FLAGS_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !flag_upd) |=> (flags_o == $past(flags_i))); // R7
  AST_SZ_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_we_o && wb_en_o) |-> (flags_o[FLG_S] == wb_data_o[W-1] &&
                                 flags_o[FLG_Z] == (wb_data_o == '0))); // R8
  AST_NO_R0_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> (wb_idx_o != '0)); // R9
  AST_ONE_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (!wb_en_o && !flags_we_o && !illegal_o)); // R10
endmodule

// File: tb/test_rx_alu_subset.sv
module test_rx_alu_subset;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [15:0] insn_lo_i = '0, insn_hi_i = '0;
  logic [31:0] src_rdata_i = '0, dst_rdata_i = '0;
  logic [3:0]  flags_i = '0;
  logic [4:0]  src_idx_o, dst_idx_o, wb_idx_o;
  logic        valid_o, wb_en_o, flags_we_o, illegal_o;
  logic [31:0] wb_data_o;
  logic [3:0]  flags_o;

  int n_chk = 0, n_fail = 0;

  typedef struct packed {
    logic        ill;
    logic        wen;
    logic [4:0]  idx;
    logic [31:0] data;
    logic        fwe;
    logic [3:0]  fl;
  } exp_t;

  exp_t  q_exp[$];
  string q_req[$];

  always #10 clk_i = ~clk_i;

  rx_alu_subset i_rx_alu_subset (
    .clk_i, .rst_ni, .valid_i, .insn_lo_i, .insn_hi_i, .src_rdata_i,
    .dst_rdata_i, .flags_i, .src_idx_o, .dst_idx_o, .valid_o, .wb_en_o,
    .wb_idx_o, .wb_data_o, .flags_we_o, .flags_o, .illegal_o
  );

  function automatic logic [15:0] rf(input logic [4:0] r2, input logic [5:0] opc,
                                     input logic [4:0] r1);
    return {r2, opc, r1};
  endfunction

  task automatic apply(input logic [15:0] lo, input logic [15:0] hi,
                       input logic [31:0] d1, input logic [31:0] d2,
                       input logic [3:0] fl, input string req);
    exp_t e;
    logic [5:0]  opc = lo[10:5];
    logic [4:0]  r2 = lo[15:11], r1 = lo[4:0];
    logic [31:0] a1 = (r1 == 0) ? 32'd0 : d1;
    logic [31:0] a2 = (r2 == 0) ? 32'd0 : d2;
    logic [31:0] x, y, res;
    logic [32:0] dd;
    logic        wr = 1'b1, ext = 1'b0, arith = 1'b0, logic_op = 1'b0;
    e = '0; e.fl = fl; res = '0; x = '0; y = '0;
    case (opc)
      6'b001101: begin arith = 1; x = a2; y = a1; end
      6'b001100: begin arith = 1; x = a1; y = a2; end
      6'b001011: begin logic_op = 1; wr = 0; res = a2 & a1; end
      6'b001001: begin logic_op = 1; res = a2 ^ a1; end
      6'b110101: begin logic_op = 1; res = a1 ^ {16'h0, hi}; end
      6'b000100: begin ext = 1; res = {24'h0, a1[7:0]}; end
      6'b000101: begin ext = 1; res = {{24{a1[7]}}, a1[7:0]}; end
      6'b000110: begin ext = 1; res = {16'h0, a1[15:0]}; end
      6'b000111: begin ext = 1; res = {{16{a1[15]}}, a1[15:0]}; end
      default:   e.ill = 1;
    endcase
    if (ext && r2 != 0) begin e.ill = 1; ext = 0; end
    if (arith) begin
      dd = {1'b0, x} - {1'b0, y};
      res = dd[31:0];
      e.fl[3] = dd[32];
      e.fl[2] = (x[31] != y[31]) && (res[31] != x[31]);
    end
    if (arith || logic_op) begin
      if (logic_op) e.fl[2] = 1'b0;
      e.fl[1] = res[31];
      e.fl[0] = (res == 0);
      e.fwe = 1'b1;
    end
    if (!e.ill) begin
      e.idx  = ext ? r1 : r2;
      e.wen  = wr && (e.idx != 0);
      e.data = res;
    end
    @(negedge clk_i);
    valid_i = 1; insn_lo_i = lo; insn_hi_i = hi;
    src_rdata_i = d1; dst_rdata_i = d2; flags_i = fl;
    q_exp.push_back(e);
    q_req.push_back(req);
  endtask

  task automatic idle();
    @(negedge clk_i);
    valid_i = 0; insn_lo_i = 16'hFFFF; src_rdata_i = 32'hDEAD_BEEF;
  endtask

  // monitor: compares each result as it leaves the stage
  initial begin
    forever begin
      @(posedge clk_i); #1;
      if (rst_ni && valid_o) begin
        exp_t  e;
        string req;
        n_chk++;
        if (q_exp.size() == 0) begin
          n_fail++;
          $display("FAIL R10: unexpected valid_o act=1 exp=0");
        end else begin
          e = q_exp.pop_front(); req = q_req.pop_front();
          if (illegal_o !== e.ill || wb_en_o !== e.wen || flags_we_o !== e.fwe ||
              flags_o !== e.fl || (e.wen && (wb_idx_o !== e.idx || wb_data_o !== e.data))) begin
            n_fail++;
            $display("FAIL %s: act ill=%b wen=%b idx=%0d data=%h fwe=%b fl=%b exp ill=%b wen=%b idx=%0d data=%h fwe=%b fl=%b",
                     req, illegal_o, wb_en_o, wb_idx_o, wb_data_o, flags_we_o, flags_o,
                     e.ill, e.wen, e.idx, e.data, e.fwe, e.fl);
          end
        end
      end
    end
  end

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: act=timeout exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    valid_i = 1; insn_lo_i = rf(5'd3, 6'b001101, 5'd4); src_rdata_i = 32'h5; dst_rdata_i = 32'h9;
    repeat (3) @(negedge clk_i);
    n_chk++;
    if ({valid_o, wb_en_o, wb_idx_o, wb_data_o, flags_we_o, flags_o, illegal_o} !== '0) begin
      n_fail++;
      $display("FAIL R11: act outputs=%h exp=0",
               {valid_o, wb_en_o, wb_idx_o, wb_data_o, flags_we_o, flags_o, illegal_o});
    end
    valid_i = 0;
    rst_ni = 1;
    idle();

    apply(rf(5'd2, 6'b001101, 5'd3), 16'h0, 32'd3, 32'd10, 4'b0000, "R2 sub plain");
    apply(rf(5'd2, 6'b001101, 5'd3), 16'h0, 32'd10, 32'd3, 4'b0000, "R2 sub borrow");
    apply(rf(5'd5, 6'b001101, 5'd6), 16'h0, 32'd1, 32'h8000_0000, 4'b0000, "R2 sub overflow");
    apply(rf(5'd5, 6'b001101, 5'd6), 16'h0, 32'h1234, 32'h1234, 4'b1111, "R2 R8 sub zero");
    apply(rf(5'd7, 6'b001100, 5'd8), 16'h0, 32'd10, 32'd3, 4'b1111, "R3 subr plain");
    apply(rf(5'd7, 6'b001100, 5'd8), 16'h0, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'b0000, "R3 subr overflow");
    idle();
    apply(rf(5'd9, 6'b001011, 5'd10), 16'h0, 32'h0F0F_0000, 32'hF0F0_FFFF, 4'b1100, "R4 tst zero");
    apply(rf(5'd9, 6'b001011, 5'd10), 16'h0, 32'h8000_0001, 32'h8000_0000, 4'b0100, "R4 tst negative");
    apply(rf(5'd11, 6'b001001, 5'd12), 16'h0, 32'hA5A5_A5A5, 32'h5A5A_5A5A, 4'b1100, "R5 xor");
    apply(rf(5'd11, 6'b001001, 5'd12), 16'h0, 32'h1357_9BDF, 32'h1357_9BDF, 4'b0110, "R5 R8 xor zero");
    apply(rf(5'd13, 6'b110101, 5'd14), 16'hFFFF, 32'h8000_0000, 32'h0, 4'b1100, "R6 xori");
    apply(rf(5'd13, 6'b110101, 5'd14), 16'h8001, 32'h0000_8001, 32'h0, 4'b0100, "R6 xori zero");
    apply(rf(5'd0, 6'b000100, 5'd15), 16'h0, 32'hFFFF_FF80, 32'h0, 4'b1010, "R7 zxb");
    apply(rf(5'd0, 6'b000101, 5'd15), 16'h0, 32'h0000_0080, 32'h0, 4'b0101, "R7 sxb");
    apply(rf(5'd0, 6'b000101, 5'd15), 16'h0, 32'hFFFF_FF7F, 32'h0, 4'b0000, "R7 sxb positive");
    apply(rf(5'd0, 6'b000110, 5'd16), 16'h0, 32'hFFFF_8000, 32'h0, 4'b1111, "R7 zxh");
    apply(rf(5'd0, 6'b000111, 5'd16), 16'h0, 32'h0000_8000, 32'h0, 4'b0011, "R7 sxh");
    idle();
    apply(rf(5'd4, 6'b000101, 5'd15), 16'h0, 32'h80, 32'h0, 4'b1001, "R1 ext nonzero field");
    apply(rf(5'd4, 6'b111111, 5'd15), 16'h0, 32'h80, 32'h1, 4'b0110, "R1 unknown opcode");
    apply(rf(5'd4, 6'b000000, 5'd15), 16'h0, 32'h80, 32'h1, 4'b1010, "R1 opcode zero");
    apply(rf(5'd0, 6'b001101, 5'd3), 16'h0, 32'd1, 32'hFFFF_FFFF, 4'b0000, "R9 dest r0 discarded");
    apply(rf(5'd6, 6'b001001, 5'd0), 16'h0, 32'hFFFF_FFFF, 32'h0000_00F0, 4'b0000, "R9 src r0 reads zero");
    apply(rf(5'd0, 6'b001100, 5'd0), 16'h0, 32'h7, 32'h9, 4'b0000, "R9 both r0");
    apply(rf(5'd0, 6'b000111, 5'd0), 16'h0, 32'hFFFF_FFFF, 32'h0, 4'b0101, "R9 R7 ext r0");
    idle();
    // R10: idle stage must show no write, flag strobe or illegal
    @(negedge clk_i);
    n_chk++;
    if (valid_o !== 0 || wb_en_o !== 0 || flags_we_o !== 0 || illegal_o !== 0) begin
      n_fail++;
      $display("FAIL R10: act v/w/f/i=%b%b%b%b exp=0000", valid_o, wb_en_o, flags_we_o, illegal_o);
    end
    repeat (3) @(negedge clk_i);
    n_chk++;
    if (q_exp.size() != 0) begin
      n_fail++;
      $display("FAIL R10: act pending=%0d exp=0", q_exp.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule